// File: doc/BRIEF.md
# Shared Register Transfer Bus

This block is the 16-bit shared transfer path of a small accumulator machine. A 3-bit source select places exactly one value on the bus. The sources are six registers and the memory read port. Every register can take the bus value on the next clock edge. The block holds two 12-bit registers: an address register and a program counter. These sit on the 16-bit bus by zero-extension when they drive it and by truncation when they load from it.

The address register is the only source of the memory address. A memory write stores whatever is on the bus at that moment. Each register has its own control set. The data, accumulator and temporary registers and both 12-bit registers have load, increment and clear. The instruction register can only be loaded. Arithmetic, decode and the memory array sit outside the block.

Top module: `xbus_core`

## Requirements
- R1: While `rst_n` is low, every register output (`adr_q`, `prg_q`, `dat_q`, `acc_q`, `ins_q`, `tmp_q`) is zero.
- R2: `bus_q` follows `bus_sel` combinationally with this fixed source map: 1 address register, 2 program counter, 3 data register, 4 accumulator, 5 instruction register, 6 temporary register, 7 `mem_rdata`.
- R3: Select code 0 drives all zeros onto `bus_q`.
- R4: When the address register or the program counter drives the bus, bus bits 15:12 are zero and bits 11:0 carry the register.
- R5: A register whose load is high, and whose clear is low, holds the bus value after the next rising clock edge. A 12-bit register keeps only bus bits 11:0.
- R6: When several controls of one register are high together, clear wins over load, and load wins over increment.
- R7: Increment adds one with wrap-around: the 12-bit registers go from 0xFFF to 0x000 and the 16-bit registers go from 0xFFFF to 0x0000.
- R8: The instruction register has only a load control. It keeps its value in every cycle where `ins_ld` is low, whatever the other registers do.
- R9: `mem_addr` always equals the address register and `mem_wdata` always equals `bus_q`. `mem_we` follows `mem_wr`, so a write stores the current bus value at the current address.
- R10: A register with none of its controls high keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 3 | Bus source select code |
| adr_ld | input | 1 | Address register load from bus |
| adr_inc | input | 1 | Address register increment |
| adr_clr | input | 1 | Address register clear |
| prg_ld | input | 1 | Program counter load from bus |
| prg_inc | input | 1 | Program counter increment |
| prg_clr | input | 1 | Program counter clear |
| dat_ld | input | 1 | Data register load from bus |
| dat_inc | input | 1 | Data register increment |
| dat_clr | input | 1 | Data register clear |
| acc_ld | input | 1 | Accumulator load from bus |
| acc_inc | input | 1 | Accumulator increment |
| acc_clr | input | 1 | Accumulator clear |
| ins_ld | input | 1 | Instruction register load from bus |
| tmp_ld | input | 1 | Temporary register load from bus |
| tmp_inc | input | 1 | Temporary register increment |
| tmp_clr | input | 1 | Temporary register clear |
| mem_rdata | input | 16 | Memory read data, bus source 7 |
| mem_wr | input | 1 | Memory write request |
| bus_q | output | 16 | Current bus value |
| adr_q | output | 12 | Address register |
| prg_q | output | 12 | Program counter |
| dat_q | output | 16 | Data register |
| acc_q | output | 16 | Accumulator |
| ins_q | output | 16 | Instruction register |
| tmp_q | output | 16 | Temporary register |
| mem_addr | output | 12 | Memory address, taken from the address register |
| mem_wdata | output | 16 | Memory write data, equal to the bus |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bus value and the memory address, write data and strobe are combinational, so they are due in the same cycle as the select and controls. The bench checks them half a nanosecond after driving on the falling edge. Every register result (load, increment, clear, priority, hold) is due one rising edge later. The driver therefore queues the expected register set, and the monitor pops and compares it one nanosecond after the following rising edge. Memory read-back is checked on the step after a write, once the written word can reach the bus through select 7.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SRC_NONE = 3'd0,
      SRC_ADR  = 3'd1,
      SRC_PRG  = 3'd2,
      SRC_DAT  = 3'd3,
      SRC_ACC  = 3'd4,
      SRC_INS  = 3'd5,
      SRC_TMP  = 3'd6,
      SRC_MEM  = 3'd7
   } src_e;
endpackage

// File: rtl/xbus_reg.sv
module xbus_reg #(
   parameter int W       = 16,
   parameter bit HAS_INC = 1'b1,
   parameter bit HAS_CLR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         inc,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic         inc_en;
   logic         clr_en;
   logic [W-1:0] q_inc;

   assign inc_en = HAS_INC ? inc : 1'b0;
   assign clr_en = HAS_CLR ? clr : 1'b0;

   generate
      if (HAS_INC) begin : g_inc
         assign q_inc = q + W'(1);
      end else begin : g_noinc
         assign q_inc = q;
      end
   endgenerate

   // clear over load over increment
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clr_en) q <= '0;
      else if (ld)     q <= d;
      else if (inc_en) q <= q_inc;
   end
endmodule

// File: rtl/xbus_mux.sv
module xbus_mux
   import xbus_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] adr,
   input  logic [ADDR_W-1:0] prg,
   input  logic [DATA_W-1:0] dat,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] ins,
   input  logic [DATA_W-1:0] tmp,
   input  logic [DATA_W-1:0] mem,
   output logic [DATA_W-1:0] bus
);
   logic [DATA_W-1:0] adr_x;
   logic [DATA_W-1:0] prg_x;

   generate
      if (DATA_W > ADDR_W) begin : g_ext
         localparam int PAD = DATA_W - ADDR_W;
         assign adr_x = {{PAD{1'b0}}, adr};
         assign prg_x = {{PAD{1'b0}}, prg};
      end else begin : g_same
         assign adr_x = adr;
         assign prg_x = prg;
      end
   endgenerate

   always_comb begin
      case (sel)
         SRC_ADR: bus = adr_x;
         SRC_PRG: bus = prg_x;
         SRC_DAT: bus = dat;
         SRC_ACC: bus = acc;
         SRC_INS: bus = ins;
         SRC_TMP: bus = tmp;
         SRC_MEM: bus = mem;
         default: bus = '0;
      endcase
   end
endmodule

// File: rtl/xbus_core.sv
module xbus_core
   import xbus_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  bus_sel,
   input  logic              adr_ld,
   input  logic              adr_inc,
   input  logic              adr_clr,
   input  logic              prg_ld,
   input  logic              prg_inc,
   input  logic              prg_clr,
   input  logic              dat_ld,
   input  logic              dat_inc,
   input  logic              dat_clr,
   input  logic              acc_ld,
   input  logic              acc_inc,
   input  logic              acc_clr,
   input  logic              ins_ld,
   input  logic              tmp_ld,
   input  logic              tmp_inc,
   input  logic              tmp_clr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_wr,
   output logic [DATA_W-1:0] bus_q,
   output logic [ADDR_W-1:0] adr_q,
   output logic [ADDR_W-1:0] prg_q,
   output logic [DATA_W-1:0] dat_q,
   output logic [DATA_W-1:0] acc_q,
   output logic [DATA_W-1:0] ins_q,
   output logic [DATA_W-1:0] tmp_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we
);
   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_w
         $error("xbus_core: ADDR_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] bus_lo;
   assign bus_lo = bus_q[ADDR_W-1:0];

   xbus_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
      .sel(bus_sel), .adr(adr_q), .prg(prg_q), .dat(dat_q), .acc(acc_q),
      .ins(ins_q), .tmp(tmp_q), .mem(mem_rdata), .bus(bus_q)
   );

   xbus_reg #(.W(ADDR_W)) u_adr (
      .clk(clk), .rst_n(rst_n), .ld(adr_ld), .inc(adr_inc), .clr(adr_clr),
      .d(bus_lo), .q(adr_q)
   );

   xbus_reg #(.W(ADDR_W)) u_prg (
      .clk(clk), .rst_n(rst_n), .ld(prg_ld), .inc(prg_inc), .clr(prg_clr),
      .d(bus_lo), .q(prg_q)
   );

   xbus_reg #(.W(DATA_W)) u_dat (
      .clk(clk), .rst_n(rst_n), .ld(dat_ld), .inc(dat_inc), .clr(dat_clr),
      .d(bus_q), .q(dat_q)
   );

   xbus_reg #(.W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .ld(acc_ld), .inc(acc_inc), .clr(acc_clr),
      .d(bus_q), .q(acc_q)
   );

   xbus_reg #(.W(DATA_W), .HAS_INC(1'b0), .HAS_CLR(1'b0)) u_ins (
      .clk(clk), .rst_n(rst_n), .ld(ins_ld), .inc(1'b0), .clr(1'b0),
      .d(bus_q), .q(ins_q)
   );

   xbus_reg #(.W(DATA_W)) u_tmp (
      .clk(clk), .rst_n(rst_n), .ld(tmp_ld), .inc(tmp_inc), .clr(tmp_clr),
      .d(bus_q), .q(tmp_q)
   );

   assign mem_addr  = adr_q;
   assign mem_wdata = bus_q;
   assign mem_we    = mem_wr;
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        bus_sel,
   input logic [DATA_W-1:0] bus_q,
   input logic [ADDR_W-1:0] adr_q,
   input logic [ADDR_W-1:0] prg_q,
   input logic [DATA_W-1:0] dat_q,
   input logic [DATA_W-1:0] acc_q,
   input logic [DATA_W-1:0] ins_q,
   input logic              adr_ld,
   input logic              adr_inc,
   input logic              adr_clr,
   input logic              prg_ld,
   input logic              prg_clr,
   input logic              dat_clr,
   input logic              acc_ld,
   input logic              acc_inc,
   input logic              acc_clr,
   input logic              ins_ld,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel == 3'd0 |-> bus_q == '0);

   assert_adr_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel == 3'd1 |-> bus_q == DATA_W'(adr_q));

   assert_prg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_ld && !prg_clr) |=> prg_q == $past(bus_q[ADDR_W-1:0]));

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dat_clr |=> dat_q == '0);

   assert_adr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adr_inc && !adr_ld && !adr_clr && adr_q == {ADDR_W{1'b1}}) |=> adr_q == '0);

   assert_ins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_ld |=> $stable(ins_q));

   assert_mem_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr == adr_q) && (mem_wdata == bus_q));

   assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_ld && !acc_inc && !acc_clr) |=> $stable(acc_q));
endmodule

bind xbus_core xbus_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_q(bus_q),
   .adr_q(adr_q), .prg_q(prg_q), .dat_q(dat_q), .acc_q(acc_q), .ins_q(ins_q),
   .adr_ld(adr_ld), .adr_inc(adr_inc), .adr_clr(adr_clr),
   .prg_ld(prg_ld), .prg_clr(prg_clr), .dat_clr(dat_clr),
   .acc_ld(acc_ld), .acc_inc(acc_inc), .acc_clr(acc_clr),
   .ins_ld(ins_ld), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/xbus_core_tb_top.sv
`timescale 1ns/1ps
module xbus_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_sel = 3'd0;
   logic [5:0]  ld_v = '0, inc_v = '0, clr_v = '0; // 0 adr,1 prg,2 dat,3 acc,4 ins,5 tmp
   logic        mem_wr = 1'b0;
   logic [15:0] mem_rdata;
   logic [15:0] bus_q, dat_q, acc_q, ins_q, tmp_q, mem_wdata;
   logic [11:0] adr_q, prg_q, mem_addr;
   logic        mem_we;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   logic [15:0] mem [0:255];
   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

   xbus_core dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
      .adr_ld(ld_v[0]), .adr_inc(inc_v[0]), .adr_clr(clr_v[0]),
      .prg_ld(ld_v[1]), .prg_inc(inc_v[1]), .prg_clr(clr_v[1]),
      .dat_ld(ld_v[2]), .dat_inc(inc_v[2]), .dat_clr(clr_v[2]),
      .acc_ld(ld_v[3]), .acc_inc(inc_v[3]), .acc_clr(clr_v[3]),
      .ins_ld(ld_v[4]),
      .tmp_ld(ld_v[5]), .tmp_inc(inc_v[5]), .tmp_clr(clr_v[5]),
      .mem_rdata(mem_rdata), .mem_wr(mem_wr),
      .bus_q(bus_q), .adr_q(adr_q), .prg_q(prg_q), .dat_q(dat_q),
      .acc_q(acc_q), .ins_q(ins_q), .tmp_q(tmp_q),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
   );

   typedef struct {
      logic [11:0] adr, prg;
      logic [15:0] dat, acc, ins, tmp;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [11:0] m_adr = '0, m_prg = '0;
   logic [15:0] m_dat = '0, m_acc = '0, m_ins = '0, m_tmp = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_bus(input logic [2:0] s);
      case (s)
         3'd1: return {4'h0, m_adr};
         3'd2: return {4'h0, m_prg};
         3'd3: return m_dat;
         3'd4: return m_acc;
         3'd5: return m_ins;
         3'd6: return m_tmp;
         3'd7: return mem[m_adr[7:0]];
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] nxt(input logic [15:0] cur, input logic [15:0] b,
                                       input bit l, input bit i, input bit c,
                                       input logic [15:0] mask);
      if (c) return 16'h0;
      if (l) return b & mask;
      if (i) return (cur + 16'd1) & mask;
      return cur;
   endfunction

   task automatic step(input logic [2:0] s, input logic [5:0] l, input logic [5:0] i,
                       input logic [5:0] c, input bit we, input string tag);
      logic [15:0] b;
      exp_t e;
      @(negedge clk);
      bus_sel = s; ld_v = l; inc_v = i; clr_v = c; mem_wr = we;
      #0.5;
      b = exp_bus(s);
      check(bus_q === b, tag, "bus", bus_q, b);
      check(mem_addr === m_adr, "R9", "mem_addr", {4'h0, mem_addr}, {4'h0, m_adr});
      check(mem_wdata === b, "R9", "mem_wdata", mem_wdata, b);
      check(mem_we === we, "R9", "mem_we", {15'h0, mem_we}, {15'h0, we});
      m_adr = nxt({4'h0, m_adr}, b, l[0], i[0], c[0], 16'h0FFF);
      m_prg = nxt({4'h0, m_prg}, b, l[1], i[1], c[1], 16'h0FFF);
      m_dat = nxt(m_dat, b, l[2], i[2], c[2], 16'hFFFF);
      m_acc = nxt(m_acc, b, l[3], i[3], c[3], 16'hFFFF);
      m_ins = nxt(m_ins, b, l[4], 1'b0, 1'b0, 16'hFFFF);
      m_tmp = nxt(m_tmp, b, l[5], i[5], c[5], 16'hFFFF);
      e.adr = m_adr; e.prg = m_prg; e.dat = m_dat; e.acc = m_acc;
      e.ins = m_ins; e.tmp = m_tmp; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: register results are due one rising edge after the drive
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(adr_q === e.adr, e.tag, "adr_q", {4'h0, adr_q}, {4'h0, e.adr});
         check(prg_q === e.prg, e.tag, "prg_q", {4'h0, prg_q}, {4'h0, e.prg});
         check(dat_q === e.dat, e.tag, "dat_q", dat_q, e.dat);
         check(acc_q === e.acc, e.tag, "acc_q", acc_q, e.acc);
         check(ins_q === e.ins, e.tag, "ins_q", ins_q, e.ins);
         check(tmp_q === e.tmp, e.tag, "tmp_q", tmp_q, e.tmp);
      end
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = {k[7:0] ^ 8'h5A, k[7:0]};
      mem[0]     = 16'h0010;
      mem[8'h10] = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({adr_q, prg_q} === 24'h0, "R1", "adr/prg", {4'h0, adr_q}, 16'h0);
      check(dat_q === 16'h0 && acc_q === 16'h0, "R1", "dat/acc", dat_q | acc_q, 16'h0);
      check(ins_q === 16'h0 && tmp_q === 16'h0, "R1", "ins/tmp", ins_q | tmp_q, 16'h0);
      rst_n = 1'b1;

      step(3'd7, 6'b000001, 6'b0, 6'b0, 1'b0, "R5");   // adr <- 0x010
      step(3'd7, 6'b111110, 6'b0, 6'b0, 1'b0, "R5");   // all <- FFFF, prg truncated
      step(3'd7, 6'b000001, 6'b0, 6'b0, 1'b0, "R5");   // adr <- FFF
      step(3'd1, 6'b0, 6'b0, 6'b0, 1'b0, "R4");        // 0x0FFF on bus
      step(3'd2, 6'b0, 6'b0, 6'b0, 1'b0, "R4");
      step(3'd0, 6'b0, 6'b101111, 6'b0, 1'b0, "R7");   // all wrap to 0, ins holds
      step(3'd5, 6'b0, 6'b0, 6'b0, 1'b0, "R2");        // ins still FFFF
      step(3'd0, 6'b000100, 6'b0, 6'b0, 1'b0, "R3");   // dat <- 0
      step(3'd5, 6'b101000, 6'b101000, 6'b100010, 1'b0, "R6"); // tmp clr, acc ld over inc
      step(3'd6, 6'b0, 6'b001000, 6'b0, 1'b0, "R7");   // acc FFFF -> 0000
      step(3'd5, 6'b0, 6'b0, 6'b0, 1'b1, "R9");        // mem[0] <- FFFF
      step(3'd7, 6'b000100, 6'b0, 6'b0, 1'b0, "R9");   // read back
      step(3'd3, 6'b0, 6'b000100, 6'b0, 1'b0, "R7");   // dat -> 0000
      step(3'd3, 6'b0, 6'b000100, 6'b0, 1'b0, "R7");   // dat -> 0001
      step(3'd3, 6'b0, 6'b0, 6'b0, 1'b0, "R10");       // hold
      step(3'd4, 6'b0, 6'b0, 6'b0, 1'b0, "R2");
      step(3'd3, 6'b010000, 6'b0, 6'b0, 1'b0, "R8");   // ins <- 0001
      step(3'd5, 6'b0, 6'b101111, 6'b101111, 1'b0, "R8"); // others clr, ins holds
      step(3'd5, 6'b0, 6'b0, 6'b0, 1'b0, "R10");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule